// File: doc/BRIEF.md
# NAND Flash Bus Command Sequencer

This block sits between a register-programmed host and an 8-bit asynchronous NAND flash device. The host loads a column address, a row (page) address, an address-width setting and a set of strobe timings. It then writes one control word. That word picks which bus phases run, and the engine performs them in a fixed order: a first command byte, a special zero address byte, the column bytes, the row bytes, a second command byte, a wait for the device to become ready, and a data transfer of one or four bytes.

While the engine runs, START reads back as 1. A status word also reports the synchronised ready pin, an error flag and whether chip enable is being held. A hold bit in the control word keeps chip enable low after the word ends, so that several control words form one device transaction. A single 32-bit data register carries write data to the device and receives read data from it.

Top module: `nseq_top`

## Requirements
- R1: Writing the control register (select 0) with bit 31 set starts a sequence. Status bit 31 is 1 from the cycle after that write until the sequence ends, and then returns to 0.
- R2: While status bit 31 is 1, every host register write is ignored, including new control words. The data register (output `data_word`) changes only when a read sequence completes.
- R3: Control bit 16 sends a command byte taken from control bits 7:0 with CLE high. Control bit 19 sends a command byte taken from control bits 15:8, after all address bytes.
- R4: Control bit 17 sends the column register and bit 18 sends the row register, column first, each least significant byte first, with ALE high. The column byte count is config bits 5:4 plus 1 and the row byte count is config bits 7:6 plus 1 (config is select 4).
- R5: Control bit 24 sends exactly one address byte of 0x00 and suppresses the column and row bytes of that word.
- R6: Control bit 20 reads device bytes into the data register, and bit 21 writes data register bytes (select 3) to the device. Four bytes, least significant first, move only when bits 29 and 28 are both 1. Otherwise one byte moves, through bits 7:0, and a read clears bits 31:8.
- R7: Chip enable is low while a sequence runs. After the sequence it stays low only if control bit 30 was set, and that state reads back as status bit 30. No WE#/RE# strobe occurs with chip enable high.
- R8: Status bit 26 follows the ready pin (1 = ready) with two cycles of synchronisation. Status bit 27 is set by a control word that has both bits 20 and 21, which then runs no data cycle. The next started word clears bit 27.
- R9: In the wait register (select 5) each 6-bit field sets a phase length in clock cycles: bits 5:0 strobe low, 11:6 strobe high, 17:12 CLE/ALE setup, 23:18 hold and 29:24 post-command wait. A field of 0 means 1 cycle.
- R10: After the second command byte the engine waits the post-command time, then waits for the ready pin before any data phase or the end of the sequence.
- R11: WE# and RE# are never low together, and CLE and ALE are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 column, 2 row, 3 data, 4 config, 5 wait |
| reg_wdata | input | 32 | Host write data |
| status_word | output | 32 | Bit 31 START/busy, 30 CE held, 27 error, 26 ready |
| data_word | output | 32 | Data register contents |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus byte driven to the device |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus byte from the device |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench sends control words while a sequence is still running. A design that accepted them would add extra bus cycles to the scoreboard, or corrupt the data register. It varies the address widths to 2 and 3 bytes and combines the zero-address bit with column and row bits. A design that counted from the wrong config field, or failed to drop the column and row bytes, would show a mismatched address stream. It tries a transfer with only bit 29 set, which must move one byte, and a word with both read and write set, which must flag an error and move nothing. It also holds the ready pin low after a second command byte. A design that ignored the pin would end the sequence early, and a design that released chip enable despite the hold bit would be caught by the pin check.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    localparam int WFIELD_W = 6;
    localparam int WFIELD_N = 5;

    localparam int CB_CMD1 = 16;
    localparam int CB_COL  = 17;
    localparam int CB_ROW  = 18;
    localparam int CB_CMD2 = 19;
    localparam int CB_RD   = 20;
    localparam int CB_WR   = 21;
    localparam int CB_ZADR = 24;
    localparam int CB_RDY  = 26;
    localparam int CB_ERR  = 27;
    localparam int CB_WLO  = 28;
    localparam int CB_WHI  = 29;
    localparam int CB_HOLD = 30;
    localparam int CB_GO   = 31;

    typedef enum logic [1:0] {BC_CMD, BC_ADDR, BC_WR, BC_RD} bus_kind_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_CMD1, PH_ZADR, PH_COL, PH_ROW, PH_CMD2,
        PH_TWAIT, PH_RBWAIT, PH_DATA, PH_FIN
    } phase_e;

    typedef struct packed {
        logic       cmd1;
        logic       zadr;
        logic       col;
        logic       row;
        logic       cmd2;
        logic       rd;
        logic       wr;
        logic       quad;
        logic       hold;
        logic [7:0] op1;
        logic [7:0] op2;
    } ctl_s;

    function automatic ctl_s decode_ctl(logic [31:0] w);
        ctl_s c;
        c.cmd1 = w[CB_CMD1];
        c.zadr = w[CB_ZADR];
        c.col  = w[CB_COL];
        c.row  = w[CB_ROW];
        c.cmd2 = w[CB_CMD2];
        c.rd   = w[CB_RD];
        c.wr   = w[CB_WR];
        c.quad = w[CB_WHI] & w[CB_WLO];
        c.hold = w[CB_HOLD];
        c.op1  = w[7:0];
        c.op2  = w[15:8];
        return c;
    endfunction

    function automatic logic ph_enabled(phase_e p, ctl_s c);
        case (p)
            PH_CMD1:                     return c.cmd1;
            PH_ZADR:                     return c.zadr;
            PH_COL:                      return c.col & ~c.zadr;
            PH_ROW:                      return c.row & ~c.zadr;
            PH_CMD2, PH_TWAIT, PH_RBWAIT: return c.cmd2;
            PH_DATA:                     return c.rd ^ c.wr;
            default:                     return 1'b0;
        endcase
    endfunction

    function automatic phase_e next_phase(phase_e p, ctl_s c);
        phase_e r = PH_FIN;
        for (int i = int'(PH_FIN) - 1; i > int'(p); i--) begin
            if (ph_enabled(phase_e'(i), c)) r = phase_e'(i);
        end
        return r;
    endfunction

    function automatic logic [WFIELD_W-1:0] len_m1(logic [WFIELD_W-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

endpackage

// File: rtl/nseq_strobe.sv
module nseq_strobe
    import nseq_pkg::*;
#(
    parameter int WF = WFIELD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  bus_kind_e     kind_in,
    input  logic [7:0]    byte_in,
    input  logic [WF-1:0] t_setup,
    input  logic [WF-1:0] t_low,
    input  logic [WF-1:0] t_high,
    input  logic [WF-1:0] t_hold,
    input  logic [7:0]    dq_in,
    output logic          done,
    output logic [7:0]    rd_byte,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic          dq_oe,
    output logic [7:0]    dq_out
);

    typedef enum logic [2:0] {TS_IDLE, TS_SETUP, TS_LOW, TS_HIGH, TS_HOLD} ts_e;

    ts_e           st;
    bus_kind_e     kind_q;
    logic [7:0]    byte_q;
    logic [WF-1:0] cnt;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= TS_IDLE;
            kind_q  <= BC_CMD;
            byte_q  <= '0;
            cnt     <= '0;
            rd_byte <= '0;
        end else begin
            case (st)
                TS_IDLE: if (req) begin
                    st     <= TS_SETUP;
                    kind_q <= kind_in;
                    byte_q <= byte_in;
                    cnt    <= len_m1(t_setup);
                end
                TS_SETUP: if (cnt == '0) begin
                    st  <= TS_LOW;
                    cnt <= len_m1(t_low);
                end else cnt <= cnt - 1'b1;
                TS_LOW: if (cnt == '0) begin
                    st  <= TS_HIGH;
                    cnt <= len_m1(t_high);
                    if (kind_q == BC_RD) rd_byte <= dq_in;
                end else cnt <= cnt - 1'b1;
                TS_HIGH: if (cnt == '0) begin
                    st  <= TS_HOLD;
                    cnt <= len_m1(t_hold);
                end else cnt <= cnt - 1'b1;
                TS_HOLD: if (cnt == '0) st <= TS_IDLE;
                         else cnt <= cnt - 1'b1;
                default: st <= TS_IDLE;
            endcase
        end
    end

    assign active = (st != TS_IDLE);
    assign done   = (st == TS_HOLD) && (cnt == '0);
    assign cle    = active && (kind_q == BC_CMD);
    assign ale    = active && (kind_q == BC_ADDR);
    assign we_n   = !((st == TS_LOW) && (kind_q != BC_RD));
    assign re_n   = !((st == TS_LOW) && (kind_q == BC_RD));
    assign dq_oe  = active && (kind_q != BC_RD);
    assign dq_out = byte_q;

    // R11: strobes and latch enables exclusive
    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));
    a_r11_latch_excl: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

endmodule

// File: rtl/nseq_phase.sv
module nseq_phase
    import nseq_pkg::*;
#(
    parameter int WF = WFIELD_W,
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [31:0]   ctl_word,
    input  logic [AW-1:0] col_addr,
    input  logic [AW-1:0] row_addr,
    input  logic [1:0]    col_m1,
    input  logic [1:0]    row_m1,
    input  logic [DW-1:0] wr_word,
    input  logic [WF-1:0] t_busy,
    input  logic          rdy,
    input  logic          done,
    input  logic [7:0]    rd_byte,
    output logic          busy,
    output logic          hold_q,
    output logic          err_q,
    output logic          req,
    output bus_kind_e     kind,
    output logic [7:0]    bus_byte,
    output logic          commit,
    output logic [DW-1:0] rd_word
);

    phase_e        ph;
    ctl_s          c;
    logic [1:0]    idx;
    logic [1:0]    last;
    logic          inflight;
    logic          bus_ph;
    logic [WF-1:0] tcnt;
    logic [4:0]    boff;

    assign boff = {idx, 3'b000};

    always_comb begin
        case (ph)
            PH_COL:  last = col_m1;
            PH_ROW:  last = row_m1;
            PH_DATA: last = c.quad ? 2'd3 : 2'd0;
            default: last = 2'd0;
        endcase
    end

    always_comb begin
        bus_ph   = 1'b1;
        kind     = BC_CMD;
        bus_byte = 8'h00;
        case (ph)
            PH_CMD1: bus_byte = c.op1;
            PH_ZADR: kind = BC_ADDR;
            PH_COL:  begin kind = BC_ADDR; bus_byte = col_addr[boff +: 8]; end
            PH_ROW:  begin kind = BC_ADDR; bus_byte = row_addr[boff +: 8]; end
            PH_CMD2: bus_byte = c.op2;
            PH_DATA: begin
                kind     = c.rd ? BC_RD : BC_WR;
                bus_byte = c.rd ? 8'h00 : wr_word[boff +: 8];
            end
            default: bus_ph = 1'b0;
        endcase
    end

    assign req    = bus_ph && !inflight;
    assign busy   = (ph != PH_IDLE);
    assign commit = (ph == PH_FIN) && c.rd && !c.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            c        <= '0;
            idx      <= '0;
            inflight <= 1'b0;
            tcnt     <= '0;
            hold_q   <= 1'b0;
            err_q    <= 1'b0;
            rd_word  <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (launch) begin
                    c        <= decode_ctl(ctl_word);
                    ph       <= next_phase(PH_IDLE, decode_ctl(ctl_word));
                    err_q    <= ctl_word[CB_RD] & ctl_word[CB_WR];
                    idx      <= '0;
                    inflight <= 1'b0;
                    rd_word  <= '0;
                end
                PH_TWAIT: if (tcnt == '0) ph <= next_phase(ph, c);
                          else tcnt <= tcnt - 1'b1;
                PH_RBWAIT: if (rdy) ph <= next_phase(ph, c);
                PH_FIN: begin
                    ph     <= PH_IDLE;
                    hold_q <= c.hold;
                end
                default: begin
                    if (!inflight) inflight <= 1'b1;
                    else if (done) begin
                        inflight <= 1'b0;
                        if (ph == PH_DATA && c.rd) rd_word[boff +: 8] <= rd_byte;
                        if (idx == last) begin
                            idx <= '0;
                            ph  <= next_phase(ph, c);
                        end else idx <= idx + 1'b1;
                    end
                end
            endcase
            if (ph != PH_TWAIT) tcnt <= len_m1(t_busy);
        end
    end

    // R1: a start makes the engine busy
    a_r1_launch_busy: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);
    // R2: the running word cannot be replaced
    a_r2_ctl_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(c));
    // R8: conflicting data bits raise the error flag
    a_r8_err_flag: assert property (@(posedge clk) disable iff (rst)
        (launch && ctl_word[CB_RD] && ctl_word[CB_WR]) |=> err_q);
    // R10: no progress past the ready wait while the device is busy
    a_r10_rb_gate: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RBWAIT && !rdy) |=> (ph == PH_RBWAIT));

endmodule

// File: rtl/nseq_top.sv
module nseq_top
    import nseq_pkg::*;
#(
    parameter int WF = WFIELD_W,
    parameter int AW = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] status_word,
    output logic [31:0] data_word,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_out,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_in,
    input  logic        nand_rb
);

    localparam int WAIT_W = WF * WFIELD_N;
    localparam logic [2:0] SEL_CTL = 3'd0, SEL_COL = 3'd1, SEL_ROW = 3'd2,
                           SEL_DAT = 3'd3, SEL_CFG = 3'd4, SEL_WAIT = 3'd5;

    logic [AW-1:0]     col_q, row_q;
    logic [31:0]       data_q;
    logic [3:0]        cfg_q;
    logic [WAIT_W-1:0] wait_q;
    logic [1:0]        rb_sync;
    logic              busy, hold_q, err_q, launch, host_ok;
    logic              req, done, commit;
    bus_kind_e         kind;
    logic [7:0]        bus_byte, rd_byte;
    logic [31:0]       rd_word;
    logic [WF-1:0]     wf [WFIELD_N];

    assign host_ok = reg_we && !busy;
    assign launch  = host_ok && (reg_sel == SEL_CTL) && reg_wdata[CB_GO];

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q   <= '0;
            row_q   <= '0;
            data_q  <= '0;
            cfg_q   <= '0;
            wait_q  <= '0;
            rb_sync <= '0;
        end else begin
            rb_sync <= {rb_sync[0], nand_rb};
            if (commit) data_q <= rd_word;
            else if (host_ok && reg_sel == SEL_DAT) data_q <= reg_wdata;
            if (host_ok) begin
                case (reg_sel)
                    SEL_COL:  col_q  <= AW'(reg_wdata);
                    SEL_ROW:  row_q  <= AW'(reg_wdata);
                    SEL_CFG:  cfg_q  <= reg_wdata[7:4];
                    SEL_WAIT: wait_q <= reg_wdata[WAIT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    generate
        for (genvar g = 0; g < WFIELD_N; g++) begin : g_wf
            assign wf[g] = wait_q[g*WF +: WF];
        end
    endgenerate

    nseq_phase #(.WF(WF), .AW(AW), .DW(32)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .ctl_word (reg_wdata),
        .col_addr (col_q),
        .row_addr (row_q),
        .col_m1   (cfg_q[1:0]),
        .row_m1   (cfg_q[3:2]),
        .wr_word  (data_q),
        .t_busy   (wf[4]),
        .rdy      (rb_sync[1]),
        .done     (done),
        .rd_byte  (rd_byte),
        .busy     (busy),
        .hold_q   (hold_q),
        .err_q    (err_q),
        .req      (req),
        .kind     (kind),
        .bus_byte (bus_byte),
        .commit   (commit),
        .rd_word  (rd_word)
    );

    nseq_strobe #(.WF(WF)) u_strobe (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .kind_in (kind),
        .byte_in (bus_byte),
        .t_setup (wf[2]),
        .t_low   (wf[0]),
        .t_high  (wf[1]),
        .t_hold  (wf[3]),
        .dq_in   (nand_dq_in),
        .done    (done),
        .rd_byte (rd_byte),
        .cle     (nand_cle),
        .ale     (nand_ale),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .dq_oe   (nand_dq_oe),
        .dq_out  (nand_dq_out)
    );

    assign nand_ce_n = !(busy || hold_q);
    assign data_word = data_q;

    always_comb begin
        status_word          = '0;
        status_word[CB_GO]   = busy;
        status_word[CB_HOLD] = hold_q;
        status_word[CB_ERR]  = err_q;
        status_word[CB_RDY]  = rb_sync[1];
    end

    // R7: a strobe only with the device selected
    a_r7_ce_strobe: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    // R2: data register frozen while running, except the read commit
    a_r2_data_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && !commit) |=> $stable(data_q));

endmodule

// File: tb/nseq_top_test.sv
module nseq_top_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] status_word, data_word;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        nand_rb;

    int n_chk = 0;
    int n_err = 0;
    int n_ovl = 0;
    int low_cnt = 0;
    int last_low = 0;
    logic [7:0] dev_val = 8'h5A;
    logic [7:0] exp_val = 8'h5A;
    logic prev_we = 1'b1, prev_re = 1'b1;
    logic [9:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] v0, v1, v2, v3;

    always #(CLK_P/2) clk = ~clk;
    assign nand_dq_in = dev_val;

    nseq_top uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .status_word(status_word), .data_word(data_word),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // kinds: 2 cmd, 1 addr, 0 write data, 3 read data
    task automatic push(input logic [1:0] k, input logic [7:0] b, input string tag);
        exp_q.push_back({k, b});
        tag_q.push_back(tag);
    endtask

    task automatic push_rd(input string tag);
        push(2'd3, exp_val, tag);
        exp_val = exp_val + 8'h11;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (status_word[31] && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(!status_word[31], tag, status_word, 32'h0);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    // monitor: scoreboard of bus cycles
    always @(negedge clk) begin
        logic [9:0] ev;
        logic [9:0] e;
        string t;
        if (!rst) begin
            if ((!nand_we_n && !nand_re_n) || (nand_cle && nand_ale)) n_ovl++;
            if (!nand_we_n) low_cnt++;
            if (!prev_we && nand_we_n) begin
                last_low = low_cnt;
                low_cnt  = 0;
                ev = {nand_cle ? 2'd2 : (nand_ale ? 2'd1 : 2'd0), nand_dq_out};
                if (nand_ce_n) begin
                    n_chk++; n_err++;
                    $display("FAIL R7 strobe with ce_n high act=1 exp=0");
                end
                if (exp_q.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL R2/R3/R4/R5/R6 unexpected bus cycle act=%h exp=none", ev);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(e == ev, t, {22'b0, ev}, {22'b0, e});
                end
            end
            if (!prev_re && nand_re_n) begin
                ev = {2'd3, dev_val};
                dev_val = dev_val + 8'h11;
                if (exp_q.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL R6 unexpected read cycle act=%h exp=none", ev);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(e == ev, t, {22'b0, ev}, {22'b0, e});
                end
            end
        end
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0; nand_rb = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // reset state
        check(status_word[31] == 1'b0, "R1 reset idle", status_word, 0);
        check(data_word == 32'h0, "R6 reset data", data_word, 0);
        check(nand_ce_n && nand_we_n && nand_re_n, "R7 reset pins",
              {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        check(status_word[26] == 1'b1, "R8 ready bit", status_word, 32'h0400_0000);

        // page access: col 2 bytes, row 3 bytes
        wr(3'd4, 32'h90);
        wr(3'd1, 32'h1234);
        wr(3'd2, 32'hABCDEF);
        push(2'd2, 8'h00, "R3 first command");
        push(2'd1, 8'h34, "R4 col byte0");
        push(2'd1, 8'h12, "R4 col byte1");
        push(2'd1, 8'hEF, "R4 row byte0");
        push(2'd1, 8'hCD, "R4 row byte1");
        push(2'd1, 8'hAB, "R4 row byte2");
        push(2'd2, 8'h30, "R3 second command");
        wr(3'd0, 32'h800F_3000);
        check(status_word[31] == 1'b1, "R1 busy after start", status_word, 32'h8000_0000);
        wr(3'd0, 32'h8001_0090);     // ignored
        wr(3'd3, 32'h55AA_55AA);     // ignored
        wr(3'd4, 32'h00);            // ignored
        wait_idle("R1 page access done");
        check(data_word == 32'h0, "R2 data write ignored while busy", data_word, 0);
        check(nand_ce_n == 1'b1, "R7 ce released", nand_ce_n, 1);

        // config write ignored while busy: repeat address, still 2+3 bytes
        push(2'd1, 8'h34, "R2 cfg kept col0");
        push(2'd1, 8'h12, "R2 cfg kept col1");
        push(2'd1, 8'hEF, "R2 cfg kept row0");
        push(2'd1, 8'hCD, "R2 cfg kept row1");
        push(2'd1, 8'hAB, "R2 cfg kept row2");
        wr(3'd0, 32'h8006_0000);
        wait_idle("R4 address only");

        // 4-byte read with hold
        v0 = exp_val; v1 = v0 + 8'h11; v2 = v1 + 8'h11; v3 = v2 + 8'h11;
        repeat (4) push_rd("R6 quad read");
        wr(3'd0, 32'hF010_0000);
        wait_idle("R6 quad read done");
        check(data_word == {v3, v2, v1, v0}, "R6 quad read packing", data_word, {v3, v2, v1, v0});
        check(nand_ce_n == 1'b0, "R7 ce held", nand_ce_n, 0);
        check(status_word[30] == 1'b1, "R7 hold status", status_word, 32'h4000_0000);

        // single-width read: only bit 29 set
        v0 = exp_val;
        push_rd("R6 single read");
        wr(3'd0, 32'hA010_0000);
        wait_idle("R6 single read done");
        check(data_word == {24'h0, v0}, "R6 single read", data_word, {24'h0, v0});
        check(nand_ce_n == 1'b1, "R7 ce released after held word", nand_ce_n, 1);

        // writes
        wr(3'd3, 32'hDDCC_BBAA);
        push(2'd0, 8'hAA, "R6 write b0");
        push(2'd0, 8'hBB, "R6 write b1");
        push(2'd0, 8'hCC, "R6 write b2");
        push(2'd0, 8'hDD, "R6 write b3");
        wr(3'd0, 32'hB020_0000);
        wait_idle("R6 quad write done");
        push(2'd0, 8'hAA, "R6 single write");
        wr(3'd0, 32'h8020_0000);
        wait_idle("R6 single write done");

        // zero address replaces col/row
        push(2'd2, 8'h90, "R5 id command");
        push(2'd1, 8'h00, "R5 zero address");
        wr(3'd0, 32'h8107_0090);
        wait_idle("R5 zero address done");

        // read and write together
        wr(3'd0, 32'h8030_0000);
        wait_idle("R8 conflict no cycles");
        check(status_word[27] == 1'b1, "R8 error set", status_word, 32'h0800_0000);
        check(data_word == 32'hDDCC_BBAA, "R8 data untouched", data_word, 32'hDDCC_BBAA);

        // command only, ce not held
        push(2'd2, 8'hFF, "R3 reset command");
        wr(3'd0, 32'h8001_00FF);
        wait_idle("R3 reset command done");
        check(status_word[27] == 1'b0, "R8 error cleared", status_word, 0);
        check(nand_ce_n == 1'b1, "R7 ce high after reset", nand_ce_n, 1);
        check(last_low == 1, "R9 zero field is one cycle", last_low, 1);

        // strobe low length
        wr(3'd5, 32'h0000_0083);
        push(2'd2, 8'hFF, "R9 timed command");
        wr(3'd0, 32'h8001_00FF);
        wait_idle("R9 timed done");
        check(last_low == 3, "R9 low width", last_low, 3);

        // ready wait after second command
        wr(3'd5, 32'h0500_0000);
        nand_rb = 1'b0;
        repeat (3) @(negedge clk);
        check(status_word[26] == 1'b0, "R8 busy pin seen", status_word, 0);
        push(2'd2, 8'h10, "R10 second command");
        wr(3'd0, 32'h8008_1000);
        repeat (60) @(negedge clk);
        check(status_word[31] == 1'b1, "R10 waits for ready", status_word, 32'h8000_0000);
        check(exp_q.size() == 0, "R10 command sent before wait", exp_q.size(), 0);
        nand_rb = 1'b1;
        wait_idle("R10 released");

        check(n_ovl == 0, "R11 strobe overlap count", n_ovl, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule